// File: doc/BRIEF.md
# Dual-Path Sinc Decimator for a 1-Bit Delta-Sigma Stream

This block turns one 1-bit delta-sigma bit stream into two decimated results that come from two sinc filters running side by side. The precision path has order 3 or 4 and a decimation ratio of 64, 128 or 256. It delivers signed 16-bit words, each marked by a one-cycle strobe that a downstream buffer can capture. The coarse path has a fixed decimation ratio of 8 and its own order setting. It reacts within a few dozen modulator bits, and each of its results is checked against a programmable window. A result outside the window raises an overload level that can trip a power stage.

The modulator clock enters as a one-cycle enable (`mod_tick`) in the system clock domain. Each input bit counts as +1 when it is 1 and as −1 when it is 0, so a 50 % one-density decodes to zero. Three sticky event flags (result count, precision clipping and overload) each drive an interrupt line that has its own enable. One clear pulse resets all three flags.

Top module: `sinc_pair`

## Requirements
- R1: The input bit is weighted +1 for 1 and −1 for 0. With the default shift, a steady 50 % density (alternating bits) gives a precision result of 0, a 75 % density (pattern 1,1,1,0 repeating) gives +16384 and a 25 % density (1,0,0,0 repeating) gives −16384.
- R2: `pri_rate` selects the precision decimation ratio: code 0 gives 64, code 1 gives 128, and codes 2 and 3 give 256. Only cycles with `mod_tick` high advance the filters. Consecutive precision strobes are exactly D ticks apart.
- R3: `pri_order4` and `sec_order4` select order 3 (value 0) or order 4 (value 1) for their own filter. The precision result is the raw filter output shifted arithmetically right by O·log2(D)−15 bits, so a full-scale raw value of ±D^O maps to ±32768.
- R4: A scaled precision value above 32767 or below −32768 is clamped to that bound and sets the sticky clip flag. An all-ones stream gives 32767 and sets the flag. An all-zeros stream gives −32768 exactly and does not set it.
- R5: After `enable` rises, and after any change of `pri_rate`, `pri_order4` or `sec_order4` while enabled, both filters restart and each drops its first O results. The first precision strobe comes on tick (O+1)·D and the first coarse strobe on tick (O+1)·8, counted from the restart.
- R6: The coarse filter decimates by 8 and outputs `sec_data` = 0x8000 + raw (offset binary, 16-bit wrap), where raw spans ±8^O. An all-ones stream gives 0x8200 at order 3 and 0x9000 at order 4, and a 50 % stream gives 0x8000.
- R7: One cycle after each coarse strobe, `overload` takes the value (sec_data < lim_low) or (sec_data > lim_high), compared unsigned. It holds between strobes and is cleared by a restart. The window 0x0000..0xFFFF never trips.
- R8: The three flags (result count, clip, overload) stay set until `flag_clr`, which has priority over new events. `irq_count`, `irq_fovf` and `irq_ovl` equal their flag ANDed with `int_en` bit 0, 1 and 2 respectively. A flag set while its enable bit is low appears on the irq line once the enable bit is raised.
- R9: The result-count flag sets on every RESULTS_PER_IRQ-th precision strobe after a restart (default 4). The overload flag sets in every cycle in which `overload` is high.
- R10: After reset and while `enable` is low, no strobes are produced and `overload` is low, whatever the stream does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs both filters; low holds them cleared |
| mod_tick | input | 1 | One-cycle pulse per modulator bit |
| mod_bit | input | 1 | Modulator bit, valid when mod_tick is high |
| pri_rate | input | 2 | Precision decimation code (64/128/256/256) |
| pri_order4 | input | 1 | Precision filter order: 0 → 3, 1 → 4 |
| sec_order4 | input | 1 | Coarse filter order: 0 → 3, 1 → 4 |
| lim_low | input | 16 | Lower window bound for coarse results |
| lim_high | input | 16 | Upper window bound for coarse results |
| int_en | input | 3 | Irq enables: bit0 count, bit1 clip, bit2 overload |
| flag_clr | input | 1 | Clears all sticky flags |
| pri_data | output | 16 | Signed scaled precision result |
| pri_valid | output | 1 | One-cycle strobe for pri_data |
| sec_data | output | 16 | Offset-binary coarse result |
| sec_valid | output | 1 | One-cycle strobe for sec_data |
| overload | output | 1 | Coarse result outside the window |
| irq_count | output | 1 | Result-count interrupt |
| irq_fovf | output | 1 | Precision clip interrupt |
| irq_ovl | output | 1 | Overload interrupt |

## Verification
The bench counts ticks from each restart to the first strobe at two order/rate pairs and after a rate change made mid-stream. An off-by-one in the fill counter moves that first strobe a whole decimation period. Exact-fraction densities at every rate and both orders expose a wrong shift amount, a sign error in the ±1 mapping or an integrator that wraps too narrowly, as a factor-of-two or sign mismatch. An all-ones stream lands exactly on the positive bound, so a design that does not clamp wraps to −32768, while the all-zeros case catches clamping that is too eager. Window, masking and clear tests show overload levels that were not latched and irq lines that ignore their enable bits.

// File: rtl/sinc_pkg.sv
package sinc_pkg;

    localparam int OUT_W     = 16;
    localparam int MAX_ORDER = 4;
    localparam int MAX_LOG2D = 8;

    typedef enum logic [1:0] {
        RATE_64   = 2'd0,
        RATE_128  = 2'd1,
        RATE_256  = 2'd2,
        RATE_256B = 2'd3
    } rate_e;

    typedef struct packed {
        logic signed [OUT_W-1:0] value;
        logic                    clipped;
    } scaled_t;

    // signed accumulator width that holds +/- D^O without ambiguity
    function automatic int acc_width(input int order, input int log2d);
        return order * log2d + 2;
    endfunction

    function automatic logic [3:0] rate_log2(input rate_e r);
        case (r)
            RATE_64:  return 4'd6;
            RATE_128: return 4'd7;
            default:  return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sinc_cic.sv
module sinc_cic
    import sinc_pkg::*;
#(
    parameter int W     = 34,
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                restart,
    input  logic                tick,
    input  logic                bit_in,
    input  logic                order4,
    input  logic [CNT_W-1:0]    last_count,
    output logic signed [W-1:0] res,
    output logic                res_valid
);

    logic signed [W-1:0] integ [MAX_ORDER];
    logic signed [W-1:0] dly   [MAX_ORDER];
    logic signed [W-1:0] diff  [MAX_ORDER];
    logic [CNT_W-1:0]    dcnt;
    logic [2:0]          fill;
    logic [2:0]          order_n;
    logic                fire;
    logic signed [W-1:0] step;
    logic signed [W-1:0] tap;

    assign order_n = order4 ? 3'd4 : 3'd3;
    // +1 for a one, -1 for a zero
    assign step    = {{(W-1){~bit_in}}, 1'b1};
    assign fire    = tick && (dcnt == last_count);
    assign tap     = order4 ? integ[MAX_ORDER-1] : integ[MAX_ORDER-2];

    always_comb begin
        diff[0] = tap - dly[0];
        for (int i = 1; i < MAX_ORDER; i++) begin
            diff[i] = diff[i-1] - dly[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            for (int i = 0; i < MAX_ORDER; i++) begin
                integ[i] <= '0;
                dly[i]   <= '0;
            end
            dcnt      <= '0;
            fill      <= '0;
            res       <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (tick) begin
                integ[0] <= integ[0] + step;
                for (int i = 1; i < MAX_ORDER; i++) begin
                    integ[i] <= integ[i] + integ[i-1];
                end
                dcnt <= fire ? '0 : dcnt + 1'b1;
            end
            if (fire) begin
                dly[0] <= tap;
                for (int i = 1; i < MAX_ORDER; i++) begin
                    dly[i] <= diff[i-1];
                end
                if (fill == order_n) begin
                    res       <= order4 ? diff[MAX_ORDER-1] : diff[MAX_ORDER-2];
                    res_valid <= 1'b1;
                end else begin
                    fill <= fill + 3'd1;
                end
            end
        end
    end

    AST_FILL_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> !res_valid); // R5

    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(tick)); // R2

endmodule

// File: rtl/sinc_scale.sv
module sinc_scale
    import sinc_pkg::*;
#(
    parameter int IN_W = 34
) (
    input  logic signed [IN_W-1:0] raw,
    input  logic                   order4,
    input  logic [3:0]             log2d,
    output scaled_t                q
);

    localparam logic signed [IN_W-1:0] POS_LIM = IN_W'(32767);
    localparam logic signed [IN_W-1:0] NEG_LIM = -POS_LIM - IN_W'(1);

    logic [5:0]            shamt;
    logic signed [IN_W-1:0] shifted;

    always_comb begin
        // O*log2(D) - 15 keeps full scale at 2^15
        if (order4) begin
            shamt = {log2d, 2'b00} - 6'd15;
        end else begin
            shamt = {1'b0, log2d, 1'b0} + {2'b00, log2d} - 6'd15;
        end
        shifted = raw >>> shamt;
        if (shifted > POS_LIM) begin
            q.value   = 16'sh7FFF;
            q.clipped = 1'b1;
        end else if (shifted < NEG_LIM) begin
            q.value   = -16'sh7FFF - 16'sh0001;
            q.clipped = 1'b1;
        end else begin
            q.value   = shifted[OUT_W-1:0];
            q.clipped = 1'b0;
        end
    end

endmodule

// File: rtl/sinc_limit.sv
module sinc_limit
    import sinc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [OUT_W-1:0] sample,
    input  logic             sample_valid,
    input  logic [OUT_W-1:0] lim_low,
    input  logic [OUT_W-1:0] lim_high,
    output logic             overload
);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            overload <= 1'b0;
        end else if (sample_valid) begin
            overload <= (sample < lim_low) || (sample > lim_high);
        end
    end

    AST_OVL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!sample_valid && !restart) |=> $stable(overload)); // R7

endmodule

// File: rtl/sinc_pair.sv
module sinc_pair
    import sinc_pkg::*;
#(
    parameter int SEC_LOG2D       = 3,
    parameter int RESULTS_PER_IRQ = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        mod_tick,
    input  logic        mod_bit,
    input  logic [1:0]  pri_rate,
    input  logic        pri_order4,
    input  logic        sec_order4,
    input  logic [15:0] lim_low,
    input  logic [15:0] lim_high,
    input  logic [2:0]  int_en,
    input  logic        flag_clr,
    output logic [15:0] pri_data,
    output logic        pri_valid,
    output logic [15:0] sec_data,
    output logic        sec_valid,
    output logic        overload,
    output logic        irq_count,
    output logic        irq_fovf,
    output logic        irq_ovl
);

    localparam int PRI_W = acc_width(MAX_ORDER, MAX_LOG2D);
    localparam int SEC_W = acc_width(MAX_ORDER, SEC_LOG2D);
    localparam int CNT_W = $clog2(RESULTS_PER_IRQ) + 1;
    localparam logic [SEC_LOG2D-1:0] SEC_LAST = '1;

    typedef enum int { FLG_COUNT = 0, FLG_CLIP = 1, FLG_OVL = 2 } flag_e;

    logic [3:0]              cfg, cfg_q;
    logic                    restart;
    logic [3:0]              pri_log2;
    logic [MAX_LOG2D-1:0]    pri_last;
    logic signed [PRI_W-1:0] pri_raw;
    logic signed [SEC_W-1:0] sec_raw;
    scaled_t                 pri_scaled;
    logic [2:0]              flags, flag_set;
    logic [CNT_W-1:0]        res_cnt;
    logic                    cnt_hit;

    assign cfg      = {pri_rate, pri_order4, sec_order4};
    assign restart  = !enable || (cfg != cfg_q);
    assign pri_log2 = rate_log2(rate_e'(pri_rate));
    assign pri_last = MAX_LOG2D'((9'd1 << pri_log2) - 9'd1);

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg;
    end

    sinc_cic #(.W(PRI_W), .CNT_W(MAX_LOG2D)) i_pri (
        .clk(clk), .rst(rst), .restart(restart), .tick(mod_tick),
        .bit_in(mod_bit), .order4(pri_order4), .last_count(pri_last),
        .res(pri_raw), .res_valid(pri_valid)
    );

    sinc_cic #(.W(SEC_W), .CNT_W(SEC_LOG2D)) i_sec (
        .clk(clk), .rst(rst), .restart(restart), .tick(mod_tick),
        .bit_in(mod_bit), .order4(sec_order4), .last_count(SEC_LAST),
        .res(sec_raw), .res_valid(sec_valid)
    );

    sinc_scale #(.IN_W(PRI_W)) i_scale (
        .raw(pri_raw), .order4(pri_order4), .log2d(pri_log2), .q(pri_scaled)
    );

    assign pri_data = pri_scaled.value;
    assign sec_data = 16'(sec_raw) + 16'h8000;

    sinc_limit i_limit (
        .clk(clk), .rst(rst), .restart(restart),
        .sample(sec_data), .sample_valid(sec_valid),
        .lim_low(lim_low), .lim_high(lim_high), .overload(overload)
    );

    assign cnt_hit = pri_valid && (res_cnt == CNT_W'(RESULTS_PER_IRQ - 1));

    always_ff @(posedge clk) begin
        if (rst || restart)  res_cnt <= '0;
        else if (cnt_hit)    res_cnt <= '0;
        else if (pri_valid)  res_cnt <= res_cnt + 1'b1;
    end

    always_comb begin
        flag_set            = '0;
        flag_set[FLG_COUNT] = cnt_hit;
        flag_set[FLG_CLIP]  = pri_valid && pri_scaled.clipped;
        flag_set[FLG_OVL]   = overload;
    end

    always_ff @(posedge clk) begin
        if (rst)           flags <= '0;
        else if (flag_clr) flags <= '0;
        else               flags <= flags | flag_set;
    end

    assign irq_count = flags[FLG_COUNT] & int_en[0];
    assign irq_fovf  = flags[FLG_CLIP]  & int_en[1];
    assign irq_ovl   = flags[FLG_OVL]   & int_en[2];

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags[FLG_CLIP] && !flag_clr) |=> flags[FLG_CLIP]); // R8

    AST_CLIP_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_CLIP]) |-> $past(pri_valid)); // R4

    AST_COUNT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_COUNT]) |-> $past(pri_valid)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pri_valid && !sec_valid && !overload)); // R10

endmodule

// File: tb/test_sinc_pair.sv
module test_sinc_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        mod_tick = 1'b0;
    logic        mod_bit = 1'b0;
    logic [1:0]  pri_rate = 2'd0;
    logic        pri_order4 = 1'b0;
    logic        sec_order4 = 1'b0;
    logic [15:0] lim_low = 16'h0000;
    logic [15:0] lim_high = 16'hFFFF;
    logic [2:0]  int_en = 3'b000;
    logic        flag_clr = 1'b0;
    logic [15:0] pri_data, sec_data;
    logic        pri_valid, sec_valid, overload;
    logic        irq_count, irq_fovf, irq_ovl;

    int errors = 0;
    int checks = 0;
    int pri_n, sec_n, tick_no, pri_first, pri_second, sec_first;
    int pri_last, sec_last;

    sinc_pair i_sinc_pair (
        .clk(clk), .rst(rst), .enable(enable), .mod_tick(mod_tick), .mod_bit(mod_bit),
        .pri_rate(pri_rate), .pri_order4(pri_order4), .sec_order4(sec_order4),
        .lim_low(lim_low), .lim_high(lim_high), .int_en(int_en), .flag_clr(flag_clr),
        .pri_data(pri_data), .pri_valid(pri_valid), .sec_data(sec_data),
        .sec_valid(sec_valid), .overload(overload), .irq_count(irq_count),
        .irq_fovf(irq_fovf), .irq_ovl(irq_ovl)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // 0: 50%, 1: all ones, 2: all zeros, 3: 75%, 4: 25%
    function automatic logic gen(input int kind, input int idx);
        case (kind)
            0: return idx[0];
            1: return 1'b1;
            2: return 1'b0;
            3: return idx[1:0] != 2'd3;
            default: return idx[1:0] == 2'd0;
        endcase
    endfunction

    task automatic clear_counts();
        pri_n = 0; sec_n = 0; tick_no = 0;
        pri_first = 0; pri_second = 0; sec_first = 0;
    endtask

    task automatic tick1(input logic b);
        @(negedge clk);
        mod_tick = 1'b1;
        mod_bit  = b;
        @(negedge clk);
        mod_tick = 1'b0;
        tick_no++;
        if (pri_valid) begin
            pri_n++;
            pri_last = int'($signed(pri_data));
            if (pri_n == 1) pri_first = tick_no;
            if (pri_n == 2) pri_second = tick_no;
        end
        if (sec_valid) begin
            sec_n++;
            sec_last = int'(sec_data);
            if (sec_n == 1) sec_first = tick_no;
        end
    endtask

    task automatic restart_run();
        @(negedge clk) enable = 1'b0;
        @(negedge clk) enable = 1'b1;
        clear_counts();
    endtask

    task automatic measure(input int kind);
        restart_run();
        for (int k = 0; k < 2000 && pri_n < 2; k++) tick1(gen(kind, tick_no));
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 reset pri_valid", int'(pri_valid), 0);
        check("R10 reset sec_valid", int'(sec_valid), 0);
        check("R10 reset overload", int'(overload), 0);
        check("R8 reset irqs", int'({irq_count, irq_fovf, irq_ovl}), 0);
    endtask

    task automatic t_idle();
        int seen = 0;
        enable = 1'b0;
        lim_low = 16'h7F00; lim_high = 16'h8100;
        for (int k = 0; k < 100; k++) begin
            tick1(1'b1);
            if (pri_valid || sec_valid || overload) seen++;
        end
        check("R10 idle no strobes", seen, 0);
        lim_low = 16'h0000; lim_high = 16'hFFFF;
    endtask

    task automatic t_density(input logic [1:0] rate, input logic o4, input int d);
        int o = o4 ? 4 : 3;
        int fs = 1;
        for (int i = 0; i < o; i++) fs = fs * 8;
        pri_rate = rate; pri_order4 = o4; sec_order4 = o4;
        measure(0);
        check($sformatf("R1 50%% d=%0d o=%0d", d, o), pri_last, 0);
        check("R6 sec 50% offset", sec_last, 32768);
        measure(3);
        check($sformatf("R1 R3 75%% d=%0d o=%0d", d, o), pri_last, 16384);
        check("R6 sec 75%", sec_last, 32768 + fs / 2);
        measure(4);
        check($sformatf("R1 R3 25%% d=%0d o=%0d", d, o), pri_last, -16384);
        check("R6 sec 25%", sec_last, 32768 - fs / 2);
    endtask

    task automatic t_fill(input logic [1:0] rate, input logic o4, input int d);
        int o = o4 ? 4 : 3;
        pri_rate = rate; pri_order4 = o4; sec_order4 = o4;
        measure(0);
        check($sformatf("R5 first pri tick d=%0d o=%0d", d, o), pri_first, (o + 1) * d);
        check("R2 strobe spacing", pri_second - pri_first, d);
        check("R5 first sec tick", sec_first, (o + 1) * 8);
    endtask

    task automatic t_sat();
        pri_rate = 2'd1; pri_order4 = 1'b0; sec_order4 = 1'b1;
        int_en = 3'b010;
        measure(2);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R4 all zeros value", pri_last, -32768);
        measure(2);
        check("R4 all zeros no clip", int'(irq_fovf), 0);
        measure(1);
        check("R4 all ones clamp", pri_last, 32767);
        check("R4 all ones clip flag", int'(irq_fovf), 1);
        check("R6 sec ones order4", sec_last, 32'h9000);
    endtask

    task automatic t_mask();
        int_en = 3'b000;
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        pri_rate = 2'd0; pri_order4 = 1'b0;
        measure(1);
        check("R8 masked irq low", int'(irq_fovf), 0);
        @(negedge clk) int_en = 3'b010;
        @(negedge clk);
        check("R8 held flag shows on enable", int'(irq_fovf), 1);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        check("R8 clear drops flag", int'(irq_fovf), 0);
        int_en = 3'b000;
    endtask

    task automatic t_overload();
        pri_rate = 2'd0; pri_order4 = 1'b0; sec_order4 = 1'b0;
        measure(1);
        check("R7 full window no trip", int'(overload), 0);
        check("R6 sec ones order3", sec_last, 32'h8200);
        lim_low = 16'h7F00; lim_high = 16'h8100;
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        int_en = 3'b100;
        measure(1);
        check("R7 above high trips", int'(overload), 1);
        check("R8 R9 overload irq", int'(irq_ovl), 1);
        measure(0);
        check("R7 inside window clear", int'(overload), 0);
        measure(2);
        check("R7 below low trips", int'(overload), 1);
        lim_low = 16'h0000; lim_high = 16'hFFFF;
        int_en = 3'b000;
    endtask

    task automatic t_count();
        pri_rate = 2'd0; pri_order4 = 1'b0;
        int_en = 3'b001;
        restart_run();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        for (int k = 0; k < 2000 && pri_n < 3; k++) tick1(gen(0, tick_no));
        @(negedge clk);
        check("R9 three results no count irq", int'(irq_count), 0);
        for (int k = 0; k < 2000 && pri_n < 4; k++) tick1(gen(0, tick_no));
        @(negedge clk);
        check("R9 fourth result sets count irq", int'(irq_count), 1);
        int_en = 3'b000;
    endtask

    task automatic t_ratechange();
        pri_rate = 2'd0; pri_order4 = 1'b0;
        measure(0);
        pri_rate = 2'd1;
        clear_counts();
        for (int k = 0; k < 2000 && pri_n < 1; k++) tick1(gen(0, tick_no));
        check("R5 rate change refill", pri_first, 4 * 128);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle();
        t_fill(2'd0, 1'b0, 64);
        t_fill(2'd1, 1'b1, 128);
        t_density(2'd0, 1'b0, 64);
        t_density(2'd1, 1'b1, 128);
        t_density(2'd2, 1'b0, 256);
        t_density(2'd3, 1'b1, 256);
        t_sat();
        t_mask();
        t_overload();
        t_count();
        t_ratechange();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule